// File: doc/BRIEF.md
# Paired-Instruction Accumulator Sequencer

This block is the control and datapath core of a small accumulator computer. Every 40-bit memory word carries two 20-bit instructions. One memory read brings in both of them. The left instruction goes to the instruction register and the right one is parked in a buffer register. Once the left instruction has finished, the buffered right instruction runs without touching memory again. The program counter then moves to the next word.

The block drives a single-ported synchronous memory. It issues a read in one cycle and takes the data in the next. It also issues writes for stores. Every register transfer takes one state of the sequencer, so each instruction costs a fixed number of cycles whatever its opcode. A run/halt pair of flags and read-only copies of the accumulator, the extension register and the program counter let the surrounding logic watch the machine.

Top module: `acc_seq`

## Requirements
- R1: While reset is held, the program counter, accumulator and extension register read zero, `running` is 1 and `done` is 0. Execution starts at word 0.
- R2: In a word, bits 7:0 hold the left opcode and bits 19:8 the left address. Bits 27:20 hold the right opcode and bits 39:28 the right address.
- R3: The opcodes are applied to the operand M read from the instruction's address. 0x01 loads M into AC. 0x21 writes AC to that address. 0x05 adds M to AC and 0x06 subtracts M from AC, both wrapping modulo 2^40.
- R4: The cycle counts are fixed. A word whose left half halts spends 8 cycles with `running` high. A word whose two halves both execute without a jump takes 13 cycles. Within those 13 cycles, 4 are fetch, 4 run each half, and 1 moves the buffered half into the instruction register.
- R5: After both halves of a word run without a taken jump, the program counter advances by exactly one.
- R6: Opcode 0x0B forms the unsigned 80-bit product AC*M. It places the upper 40 bits in AC and the lower 40 bits in the extension register MQ.
- R7: Opcode 0x0D jumps to the left half and 0x0E to the right half of the addressed word. A taken jump drops the buffered right half. A jump to a right half runs only that half.
- R8: Opcodes 0x0F (left target) and 0x10 (right target) jump only when AC bit 39 is 0. Otherwise execution continues in order.
- R9: Opcode 0x00 halts the machine. After a halt, `done` stays 1, `running` stays 0, PC and AC hold their values, and no memory access is issued.
- R10: Any other opcode changes no register except by normal sequencing, and it writes no memory.
- R11: Each fetch and each execute issues exactly one memory read. The read data is captured in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read request; data expected next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 40 | Write data (accumulator) |
| mem_rdata | input | 40 | Read data, valid the cycle after `mem_rd` |
| running | output | 1 | Sequencer is not halted |
| done | output | 1 | Halt instruction reached |
| dbg_ac | output | 40 | Accumulator view |
| dbg_mq | output | 40 | Extension register view |
| dbg_pc | output | 12 | Program counter view |

## Verification
Seven short programs are run, each followed by a check of the final registers, the memory contents and the number of running cycles.

- A lone halt sets the minimal cycle cost.
- A straight-line program of load, add, subtract and store separates in-order execution of both halves from skipping or repeating a half. It also shows the wrap at 2^40.
- A multiply with operands that give non-zero upper and lower halves shows which half lands in each register.
- The jump programs cover the left and right targets and a conditional jump both taken and not taken. Each has a guard instruction on the wrong path that would change AC, so a dropped buffer or a wrongly executed half becomes visible.
- A program with an unused opcode shows that the opcode has no effect.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

    typedef enum logic [3:0] {
        S_FMAR, S_FRD, S_FMBR, S_FSPLIT,
        S_EMAR, S_ERD, S_EMBR, S_EOP,
        S_RLOAD, S_HALT
    } seq_st_e;

    typedef enum logic [3:0] {
        K_NOP, K_LOAD, K_STORE, K_ADD, K_SUB, K_MUL, K_JMP, K_JPOS, K_HALT
    } op_kind_e;

    localparam logic [7:0] OPC_HALT   = 8'h00;
    localparam logic [7:0] OPC_LOAD   = 8'h01;
    localparam logic [7:0] OPC_ADD    = 8'h05;
    localparam logic [7:0] OPC_SUB    = 8'h06;
    localparam logic [7:0] OPC_MUL    = 8'h0B;
    localparam logic [7:0] OPC_JMPL   = 8'h0D;
    localparam logic [7:0] OPC_JMPR   = 8'h0E;
    localparam logic [7:0] OPC_JPOSL  = 8'h0F;
    localparam logic [7:0] OPC_JPOSR  = 8'h10;
    localparam logic [7:0] OPC_STORE  = 8'h21;

endpackage

// File: rtl/accseq_opdec.sv
module accseq_opdec
    import accseq_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opc,
    output op_kind_e        kind,
    output logic            to_right
);
    always_comb begin
        kind     = K_NOP;
        to_right = 1'b0;
        if      (opc == OP_W'(OPC_HALT))  kind = K_HALT;
        else if (opc == OP_W'(OPC_LOAD))  kind = K_LOAD;
        else if (opc == OP_W'(OPC_STORE)) kind = K_STORE;
        else if (opc == OP_W'(OPC_ADD))   kind = K_ADD;
        else if (opc == OP_W'(OPC_SUB))   kind = K_SUB;
        else if (opc == OP_W'(OPC_MUL))   kind = K_MUL;
        else if (opc == OP_W'(OPC_JMPL))  kind = K_JMP;
        else if (opc == OP_W'(OPC_JMPR)) begin
            kind     = K_JMP;
            to_right = 1'b1;
        end
        else if (opc == OP_W'(OPC_JPOSL)) kind = K_JPOS;
        else if (opc == OP_W'(OPC_JPOSR)) begin
            kind     = K_JPOS;
            to_right = 1'b1;
        end
    end
endmodule

// File: rtl/accseq_alu.sv
module accseq_alu
    import accseq_pkg::*;
#(
    parameter int W = 40
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   ac,
    input  logic [W-1:0]   mq,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   ac_n,
    output logic [W-1:0]   mq_n
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(ac) * PW'(opnd);
        ac_n = ac;
        mq_n = mq;
        case (kind)
            K_LOAD: ac_n = opnd;
            K_ADD:  ac_n = ac + opnd;
            K_SUB:  ac_n = ac - opnd;
            K_MUL: begin
                ac_n = prod[PW-1:W];
                mq_n = prod[W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import accseq_pkg::*;
#(
    parameter int WORD_W = 40,
    parameter int ADDR_W = 12,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              running,
    output logic              done,
    output logic [WORD_W-1:0] dbg_ac,
    output logic [WORD_W-1:0] dbg_mq,
    output logic [ADDR_W-1:0] dbg_pc
);
    localparam int HALF_W = OP_W + ADDR_W;

    typedef struct packed {
        seq_st_e             st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   mar;
        logic [WORD_W-1:0]   mbr;
        logic [WORD_W-1:0]   ac;
        logic [WORD_W-1:0]   mq;
        logic [HALF_W-1:0]   ir;
        logic [HALF_W-1:0]   ibr;
        logic                half;
        logic                go_right;
    } regs_t;

    regs_t q, d;

    logic [OP_W-1:0]   ir_op;
    logic [ADDR_W-1:0] ir_adr;
    op_kind_e          kind;
    logic              to_right;
    logic [WORD_W-1:0] alu_ac, alu_mq;
    logic              jump_taken;

    assign ir_op  = q.ir[OP_W-1:0];
    assign ir_adr = q.ir[HALF_W-1:OP_W];

    accseq_opdec #(.OP_W(OP_W)) u_dec (
        .opc      (ir_op),
        .kind     (kind),
        .to_right (to_right)
    );

    accseq_alu #(.W(WORD_W)) u_alu (
        .kind (kind),
        .ac   (q.ac),
        .mq   (q.mq),
        .opnd (q.mbr),
        .ac_n (alu_ac),
        .mq_n (alu_mq)
    );

    assign jump_taken = (kind == K_JMP) ||
                        ((kind == K_JPOS) && !q.ac[WORD_W-1]);

    always_comb begin
        d      = q;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        case (q.st)
            S_FMAR: begin
                d.mar = q.pc;
                d.st  = S_FRD;
            end
            S_FRD: begin
                mem_rd = 1'b1;
                d.st   = S_FMBR;
            end
            S_FMBR: begin
                d.mbr = mem_rdata;
                d.st  = S_FSPLIT;
            end
            S_FSPLIT: begin
                if (q.go_right) begin
                    d.ir   = q.mbr[WORD_W-1:HALF_W];
                    d.half = 1'b1;
                end else begin
                    d.ir   = q.mbr[HALF_W-1:0];
                    d.ibr  = q.mbr[WORD_W-1:HALF_W];
                    d.half = 1'b0;
                end
                d.go_right = 1'b0;
                d.st       = S_EMAR;
            end
            S_EMAR: begin
                d.mar = ir_adr;
                d.st  = S_ERD;
            end
            S_ERD: begin
                mem_rd = 1'b1;
                d.st   = S_EMBR;
            end
            S_EMBR: begin
                d.mbr = mem_rdata;
                d.st  = S_EOP;
            end
            S_EOP: begin
                d.ac   = alu_ac;
                d.mq   = alu_mq;
                mem_wr = (kind == K_STORE);
                if (kind == K_HALT) begin
                    d.st = S_HALT;
                end else if (jump_taken) begin
                    d.pc       = ir_adr;
                    d.go_right = to_right;
                    d.st       = S_FMAR;
                end else if (!q.half) begin
                    d.st = S_RLOAD;
                end else begin
                    d.pc = q.pc + 1'b1;
                    d.st = S_FMAR;
                end
            end
            S_RLOAD: begin
                d.ir   = q.ibr;
                d.half = 1'b1;
                d.st   = S_EMAR;
            end
            default: d.st = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = q.mar;
    assign mem_wdata = q.ac;
    assign running   = (q.st != S_HALT);
    assign done      = (q.st == S_HALT);
    assign dbg_ac    = q.ac;
    assign dbg_mq    = q.mq;
    assign dbg_pc    = q.pc;

    // R9: a halted machine stays halted and quiet
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(q.pc) && $stable(q.ac)));
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd && !mem_wr));

    // R11: every read is followed by capture of the data into MBR
    p_read_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (q.st == S_FMBR || q.st == S_EMBR));

    // R4: moving the buffered half in costs no fetch and leaves PC alone
    p_buffer_nofetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RLOAD) |=> (q.st == S_EMAR && !mem_rd && $stable(q.pc)));

    // R5: PC steps by one after the right half finishes in order
    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EOP && q.half && !jump_taken && kind != K_HALT)
        |=> (q.pc == $past(q.pc) + 1'b1));

    // R7: a taken jump lands PC on the target word
    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EOP && jump_taken) |=> (q.pc == $past(ir_adr) && q.st == S_FMAR));

    // R3: a write only happens in the operate state
    p_write_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (q.st == S_EOP));
endmodule

// File: tb/tb_acc_seq.sv
module tb_acc_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [39:0] mem_wdata, mem_rdata;
    logic        running, done;
    logic [39:0] dbg_ac, dbg_mq;
    logic [11:0] dbg_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .running(running), .done(done), .dbg_ac(dbg_ac), .dbg_mq(dbg_mq),
        .dbg_pc(dbg_pc)
    );

    logic [39:0] mem [256];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct {
        string       name;
        string       req;
        logic [39:0] ac;
        logic [39:0] mq;
        logic [11:0] pc;
        int          cyc;
        bit          has_mem;
        int          maddr;
        logic [39:0] mval;
    } exp_t;

    exp_t q_exp[$];
    int   checks = 0;
    int   errors = 0;
    int   meas_cyc;
    event mon_go, mon_ack;

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] ins(logic [7:0] op, logic [11:0] adr);
        return {adr, op};
    endfunction

    function automatic logic [39:0] wrd(logic [19:0] l, logic [19:0] r);
        return {r, l};
    endfunction

    // monitor: pops the expected item and compares final machine state
    initial begin
        forever begin
            exp_t e;
            @(mon_go);
            e = q_exp.pop_front();
            chk(e.req, {e.name, " AC"}, 80'(dbg_ac), 80'(e.ac));
            chk(e.req, {e.name, " MQ"}, 80'(dbg_mq), 80'(e.mq));
            chk(e.req, {e.name, " PC"}, 80'(dbg_pc), 80'(e.pc));
            chk("R4", {e.name, " cycles"}, 80'(meas_cyc), 80'(e.cyc));
            if (e.has_mem)
                chk(e.req, {e.name, " memory"}, 80'(mem[e.maddr]), 80'(e.mval));
            -> mon_ack;
        end
    end

    task automatic start_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic run_prog(exp_t e);
        logic [11:0] pc_hold;
        logic [39:0] ac_hold;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", {e.name, " reset pc"}, 80'(dbg_pc), 80'(0));
        chk("R1", {e.name, " reset ac/mq"}, 80'({dbg_ac, dbg_mq}), 80'(0));
        chk("R1", {e.name, " reset flags"}, 80'({running, done}), 80'(2'b10));
        rst_n    = 1'b1;
        meas_cyc = 0;
        while (!done && meas_cyc < 2000) begin
            meas_cyc++;
            @(negedge clk);
        end
        q_exp.push_back(e);
        -> mon_go;
        @(mon_ack);
        // R9: halt is sticky and quiet
        pc_hold = dbg_pc;
        ac_hold = dbg_ac;
        repeat (4) begin
            @(negedge clk);
            chk("R9", {e.name, " halt hold"},
                80'({done, running, mem_rd, mem_wr, dbg_pc, dbg_ac}),
                80'({1'b1, 1'b0, 1'b0, 1'b0, pc_hold, ac_hold}));
        end
    endtask

    initial begin
        exp_t e;
        // P1: lone halt, R1 R9 R4
        start_prog();
        mem[0] = wrd(ins(8'h00, 12'd0), ins(8'h00, 12'd0));
        e = '{name:"halt", req:"R9", ac:0, mq:0, pc:0, cyc:8, has_mem:0, maddr:0, mval:0};
        run_prog(e);

        // P2: R3 R5 R11 R2 - load/add/sub/store with wrap
        start_prog();
        mem[0]  = wrd(ins(8'h01, 12'd20), ins(8'h05, 12'd21));
        mem[1]  = wrd(ins(8'h06, 12'd22), ins(8'h21, 12'd23));
        mem[2]  = wrd(ins(8'h00, 12'd0),  ins(8'h00, 12'd0));
        mem[20] = 40'd100;
        mem[21] = 40'hFF_FFFF_FFFF;
        mem[22] = 40'd200;
        e = '{name:"arith", req:"R3", ac:40'hFF_FFFF_FF9B, mq:0, pc:2, cyc:34,
              has_mem:1, maddr:23, mval:40'hFF_FFFF_FF9B};
        run_prog(e);

        // P3: R6 multiply
        start_prog();
        mem[0]  = wrd(ins(8'h01, 12'd20), ins(8'h0B, 12'd21));
        mem[1]  = wrd(ins(8'h00, 12'd0),  ins(8'h00, 12'd0));
        mem[20] = 40'h10_0000_0000;
        mem[21] = 40'h101;
        e = '{name:"mul", req:"R6", ac:40'h10, mq:40'h10_0000_0000, pc:1, cyc:21,
              has_mem:0, maddr:0, mval:0};
        run_prog(e);

        // P4: R7 jump to right half skips left half
        start_prog();
        mem[0]  = wrd(ins(8'h01, 12'd20), ins(8'h0E, 12'd3));
        mem[1]  = wrd(ins(8'h01, 12'd21), ins(8'h00, 12'd0));
        mem[3]  = wrd(ins(8'h05, 12'd21), ins(8'h05, 12'd22));
        mem[4]  = wrd(ins(8'h00, 12'd0),  ins(8'h00, 12'd0));
        mem[20] = 40'd5;
        mem[21] = 40'd1000;
        mem[22] = 40'd7;
        e = '{name:"jmp_right", req:"R7", ac:40'd12, mq:0, pc:4, cyc:29,
              has_mem:0, maddr:0, mval:0};
        run_prog(e);

        // P5: R7 jump to left half drops buffered right half
        start_prog();
        mem[0]  = wrd(ins(8'h0D, 12'd2),  ins(8'h01, 12'd21));
        mem[2]  = wrd(ins(8'h01, 12'd20), ins(8'h00, 12'd0));
        mem[20] = 40'd5;
        mem[21] = 40'd99;
        e = '{name:"jmp_left", req:"R7", ac:40'd5, mq:0, pc:2, cyc:21,
              has_mem:0, maddr:0, mval:0};
        run_prog(e);

        // P6: R8 conditional taken, then not taken on negative AC
        start_prog();
        mem[0]  = wrd(ins(8'h01, 12'd20), ins(8'h0F, 12'd2));
        mem[1]  = wrd(ins(8'h00, 12'd0),  ins(8'h00, 12'd0));
        mem[2]  = wrd(ins(8'h01, 12'd21), ins(8'h0F, 12'd5));
        mem[3]  = wrd(ins(8'h05, 12'd20), ins(8'h00, 12'd0));
        mem[5]  = wrd(ins(8'h01, 12'd22), ins(8'h00, 12'd0));
        mem[20] = 40'd5;
        mem[21] = 40'h80_0000_0000;
        mem[22] = 40'd77;
        e = '{name:"cond", req:"R8", ac:40'h80_0000_0005, mq:0, pc:3, cyc:39,
              has_mem:0, maddr:0, mval:0};
        run_prog(e);

        // P7: R10 unknown opcode is a no-op, no write
        start_prog();
        mem[0]  = wrd(ins(8'h01, 12'd20), ins(8'h77, 12'd21));
        mem[1]  = wrd(ins(8'h00, 12'd0),  ins(8'h00, 12'd0));
        mem[20] = 40'd5;
        mem[21] = 40'd321;
        e = '{name:"unknown", req:"R10", ac:40'd5, mq:0, pc:1, cyc:21,
              has_mem:1, maddr:21, mval:40'd321};
        run_prog(e);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=running expected=halted");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule